// File: doc/BRIEF.md
# Text Cursor Overlay Generator

This block decides, one character clock at a time, whether the text cursor covers the character cell being refreshed. It compares the current refresh memory address with a programmable 14-bit cursor address. It also checks that the current scanline inside the character row falls within a programmable top-to-bottom scanline band. The result is gated with display enable and with a blink phase taken from a frame counter. The output is a single registered bit that a downstream pixel stage uses to invert or replace the glyph. Character rendering, cursor colour and the raster timing counters live elsewhere.

Software programs the block through four write ports:

- A shape register that holds the top scanline and a 2-bit blink mode.
- A bottom-scanline register.
- Separate upper and lower halves of the cursor address.

A once-per-frame pulse drives the blink counter. The normal blink runs on a 16-frame period. A slow mode doubles the period. One mode value blanks the cursor outright.

Top module: `text_cursor`

## Requirements
- R1: A write on any register port is captured at the clock edge where its write enable is high and is in effect for inputs presented from the next cycle on. The shape write stores `shapeData[4:0]` as the top scanline and `shapeData[6:5]` as the mode. The upper-address write replaces address bits 13:8 and leaves bits 7:0 alone. The lower-address write replaces bits 7:0 and leaves bits 13:8 alone.
- R2: `cursorOn` is registered: it reflects the inputs presented in the previous clock cycle.
- R3: `cursorOn` can be 1 only when `memAddr` equalled the 14-bit cursor address.
- R4: `cursorOn` can be 1 only when `rowAddr` lay between the top and bottom scanlines, both ends included.
- R5: When the top scanline is numerically greater than the bottom scanline, `cursorOn` stays 0 for every row.
- R6: When `dispEn` is 0, `cursorOn` is 0 in the following cycle.
- R7: Mode value 1 keeps `cursorOn` at 0 whatever the other inputs are.
- R8: Mode values 0 and 2 show the cursor while N mod 16 is below 8, where N is the number of `frameTick` pulses since reset. The counter advances by one on each pulse and holds otherwise.
- R9: Mode value 3 shows the cursor while N mod 32 is below 16.
- R10: Reset clears `cursorOn`, the frame counter, both scanline registers, the mode and the cursor address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | input | 14 | Refresh memory address of the current cell |
| rowAddr | input | 5 | Scanline within the current character row |
| dispEn | input | 1 | High during the visible area |
| frameTick | input | 1 | One-cycle pulse once per frame |
| shapeWe | input | 1 | Write enable for the shape register |
| shapeData | input | 7 | Top scanline [4:0] and blink mode [6:5] |
| bottomWe | input | 1 | Write enable for the bottom scanline |
| bottomData | input | 5 | Bottom scanline |
| locHiWe | input | 1 | Write enable for cursor address bits 13:8 |
| locHiData | input | 6 | Cursor address bits 13:8 |
| locLoWe | input | 1 | Write enable for cursor address bits 7:0 |
| locLoData | input | 8 | Cursor address bits 7:0 |
| cursorOn | output | 1 | Cursor covers this cell on this scanline |

## Verification
The row band is swept over all 32 scanlines for several top/bottom pairs: a wide band, a single-line band, the full range, the last line alone, and two inverted pairs. This separates an inclusive compare from an exclusive one and catches a missing inversion check. The address compare is tried with the cursor address and with each of its 14 single-bit neighbours, so a dropped or stuck address bit shows up. The two halves of the address are rewritten on their own to show that each half-write is independent. The blink logic is run through 64 frames in every mode value, which tells the 8/8 phase apart from the 16/16 phase and from the forced-off value. Single-cycle probes confirm the one-cycle output latency and the display-enable gate.

// File: rtl/text_cursor_pkg.sv
package text_cursor_pkg;

  localparam int ADDR_W = 14;
  localparam int ROW_W  = 5;

  typedef enum logic [1:0] {
    MODE_BLINK     = 2'd0,
    MODE_OFF       = 2'd1,
    MODE_BLINK_ALT = 2'd2,
    MODE_SLOW      = 2'd3
  } blinkMode_e;

  typedef struct packed {
    logic blinkOn;
    logic modeOff;
  } cursorStrobe_t;

endpackage

// File: rtl/text_cursor_ctrl.sv
module text_cursor_ctrl
  import text_cursor_pkg::*;
#(
  parameter int BLINK_LOG = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameTick,
  input  logic          modeWe,
  input  logic [1:0]    modeData,
  output cursorStrobe_t strobe
);

  localparam int CNT_W = BLINK_LOG + 2;

  logic [CNT_W-1:0] frameCnt;
  blinkMode_e       modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      modeReg  <= MODE_BLINK;
    end else begin
      if (frameTick) frameCnt <= frameCnt + 1'b1;
      if (modeWe)    modeReg  <= blinkMode_e'(modeData);
    end
  end

  always_comb begin
    strobe.modeOff = (modeReg == MODE_OFF);
    if (modeReg == MODE_SLOW) strobe.blinkOn = ~frameCnt[BLINK_LOG+1];
    else                      strobe.blinkOn = ~frameCnt[BLINK_LOG];
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> frameCnt == $past(frameCnt) + 1'b1); // R8

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(frameCnt)); // R8

endmodule

// File: rtl/text_cursor_dp.sv
module text_cursor_dp
  import text_cursor_pkg::*;
#(
  parameter int AW = 14,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  cursorStrobe_t strobe,
  input  logic [AW-1:0] memAddr,
  input  logic [RW-1:0] rowAddr,
  input  logic          dispEn,
  input  logic          topWe,
  input  logic [RW-1:0] topData,
  input  logic          bottomWe,
  input  logic [RW-1:0] bottomData,
  input  logic          locHiWe,
  input  logic [AW-9:0] locHiData,
  input  logic          locLoWe,
  input  logic [7:0]    locLoData,
  output logic          cursorOn
);

  localparam int HI_W = AW - 8;

  logic [RW-1:0] topRow, bottomRow;
  logic [AW-1:0] locReg;
  logic          addrHit, rowHit, cellHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topRow    <= '0;
      bottomRow <= '0;
      locReg    <= '0;
    end else begin
      if (topWe)    topRow          <= topData;
      if (bottomWe) bottomRow       <= bottomData;
      if (locHiWe)  locReg[AW-1:8]  <= locHiData[HI_W-1:0];
      if (locLoWe)  locReg[7:0]     <= locLoData;
    end
  end

  always_comb begin
    addrHit = (memAddr == locReg);
    rowHit  = (rowAddr >= topRow) && (rowAddr <= bottomRow);
    cellHit = addrHit && rowHit && dispEn && strobe.blinkOn && !strobe.modeOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cursorOn <= 1'b0;
    else       cursorOn <= cellHit;
  end

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    cursorOn |-> $past(memAddr) == $past(locReg)); // R3

  AST_ROW_BAND: assert property (@(posedge clk) disable iff (!rstN)
    cursorOn |-> ($past(rowAddr) >= $past(topRow)) && ($past(rowAddr) <= $past(bottomRow))); // R4

  AST_INVERTED_BAND: assert property (@(posedge clk) disable iff (!rstN)
    (topRow > bottomRow) |=> !cursorOn); // R5

  AST_BLANK_AREA: assert property (@(posedge clk) disable iff (!rstN)
    !dispEn |=> !cursorOn); // R6

  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.modeOff |=> !cursorOn); // R7

endmodule

// File: rtl/text_cursor.sv
module text_cursor
  import text_cursor_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int RW        = ROW_W,
  parameter int BLINK_LOG = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] memAddr,
  input  logic [RW-1:0] rowAddr,
  input  logic          dispEn,
  input  logic          frameTick,
  input  logic          shapeWe,
  input  logic [RW+1:0] shapeData,
  input  logic          bottomWe,
  input  logic [RW-1:0] bottomData,
  input  logic          locHiWe,
  input  logic [AW-9:0] locHiData,
  input  logic          locLoWe,
  input  logic [7:0]    locLoData,
  output logic          cursorOn
);

  cursorStrobe_t strobe;

  text_cursor_ctrl #(.BLINK_LOG(BLINK_LOG)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .modeWe    (shapeWe),
    .modeData  (shapeData[RW+1:RW]),
    .strobe    (strobe)
  );

  text_cursor_dp #(.AW(AW), .RW(RW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .rowAddr    (rowAddr),
    .dispEn     (dispEn),
    .topWe      (shapeWe),
    .topData    (shapeData[RW-1:0]),
    .bottomWe   (bottomWe),
    .bottomData (bottomData),
    .locHiWe    (locHiWe),
    .locHiData  (locHiData),
    .locLoWe    (locLoWe),
    .locLoData  (locLoData),
    .cursorOn   (cursorOn)
  );

endmodule

// File: tb/text_cursor_test.sv
module text_cursor_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [13:0] memAddr;
  logic [4:0]  rowAddr;
  logic        dispEn, frameTick;
  logic        shapeWe, bottomWe, locHiWe, locLoWe;
  logic [6:0]  shapeData;
  logic [4:0]  bottomData;
  logic [5:0]  locHiData;
  logic [7:0]  locLoData;
  logic        cursorOn;

  int compared = 0;
  int mismatched = 0;
  int frames = 0;
  int mTop = 0, mBot = 0, mMode = 0, mLoc = 0;

  always #5 clk = ~clk;

  text_cursor uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .rowAddr(rowAddr),
    .dispEn(dispEn), .frameTick(frameTick),
    .shapeWe(shapeWe), .shapeData(shapeData),
    .bottomWe(bottomWe), .bottomData(bottomData),
    .locHiWe(locHiWe), .locHiData(locHiData),
    .locLoWe(locLoWe), .locLoData(locLoData),
    .cursorOn(cursorOn)
  );

  function automatic logic model(int addr, int row, logic de);
    logic phase;
    if (mMode == 1)      phase = 1'b0;
    else if (mMode == 3) phase = (frames % 32) < 16;
    else                 phase = (frames % 16) < 8;
    return de && (addr == mLoc) && (row >= mTop) && (row <= mBot) && phase;
  endfunction

  task automatic compare(logic got, logic exp, string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: cursorOn=%0b expected=%0b (addr=%h row=%0d top=%0d bot=%0d mode=%0d frames=%0d)",
               req, got, exp, memAddr, rowAddr, mTop, mBot, mMode, frames);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks.
  task automatic probe(int addr, int row, logic de, string req);
    memAddr = addr[13:0];
    rowAddr = row[4:0];
    dispEn  = de;
    @(negedge clk);
    compare(cursorOn, model(addr, row, de), req);
  endtask

  task automatic setShape(int top, int mode);
    shapeData = {mode[1:0], top[4:0]};
    shapeWe = 1'b1;
    @(negedge clk);
    shapeWe = 1'b0;
    mTop = top; mMode = mode;
  endtask

  task automatic setBottom(int bot);
    bottomData = bot[4:0];
    bottomWe = 1'b1;
    @(negedge clk);
    bottomWe = 1'b0;
    mBot = bot;
  endtask

  task automatic setLocHi(int hi);
    locHiData = hi[5:0];
    locHiWe = 1'b1;
    @(negedge clk);
    locHiWe = 1'b0;
    mLoc = (hi[5:0] << 8) | (mLoc & 8'hFF);
  endtask

  task automatic setLocLo(int lo);
    locLoData = lo[7:0];
    locLoWe = 1'b1;
    @(negedge clk);
    locLoWe = 1'b0;
    mLoc = (mLoc & 14'h3F00) | lo[7:0];
  endtask

  task automatic pulseFrame();
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
    frames++;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int tops[6] = '{0, 3, 5, 0, 31, 10};
    int bots[6] = '{7, 3, 2, 31, 31, 4};
    rstN = 1'b0; memAddr = '0; rowAddr = '0; dispEn = 1'b1; frameTick = 1'b0;
    shapeWe = 1'b0; bottomWe = 1'b0; locHiWe = 1'b0; locLoWe = 1'b0;
    shapeData = '0; bottomData = '0; locHiData = '0; locLoData = '0;
    repeat (3) @(negedge clk);
    compare(cursorOn, 1'b0, "R10 output in reset");
    rstN = 1'b1;
    // Registers all zero, counter zero: address 0 row 0 must light the cursor.
    probe(0, 0, 1'b1, "R10 cleared registers");
    probe(0, 1, 1'b1, "R10 cleared bottom row");

    // R2: latency of one cycle.
    setLocHi(6'h12); setLocLo(8'h34);
    setShape(2, 0); setBottom(6);
    probe(14'h0000, 3, 1'b1, "R2 miss first");
    memAddr = 14'h1234;
    #1;
    compare(cursorOn, 1'b0, "R2 not yet updated");
    @(negedge clk);
    compare(cursorOn, 1'b1, "R2 updated after one edge");

    // R4 and R5: row band sweeps, including inverted pairs.
    for (int p = 0; p < 6; p++) begin
      setShape(tops[p], 0);
      setBottom(bots[p]);
      for (int r = 0; r < 32; r++)
        probe(mLoc, r, 1'b1, (tops[p] > bots[p]) ? "R5 inverted band" : "R4 row band");
    end

    // R3 and R1: address neighbours and independent half writes.
    setShape(0, 0); setBottom(31);
    setLocHi(6'h3F); setLocLo(8'hFF);
    probe(14'h3FFF, 4, 1'b1, "R1 full address");
    for (int b = 0; b < 14; b++)
      probe(14'h3FFF ^ (14'h1 << b), 4, 1'b1, "R3 address bit");
    setLocLo(8'h00);
    probe(14'h3F00, 4, 1'b1, "R1 low half only");
    probe(14'h3FFF, 4, 1'b1, "R1 old low half gone");
    setLocHi(6'h05);
    probe(14'h0500, 4, 1'b1, "R1 high half only");
    probe(14'h3F00, 4, 1'b1, "R1 old high half gone");

    // R6: display enable gate.
    probe(mLoc, 9, 1'b0, "R6 blank area");
    probe(mLoc, 9, 1'b1, "R6 visible area");
    probe(mLoc, 9, 1'b0, "R6 blank again");

    // R7, R8, R9: blink modes over 64 frames each.
    setShape(2, 0); setBottom(5);
    for (int m = 0; m < 4; m++) begin
      setShape(2, m);
      for (int f = 0; f < 64; f++) begin
        probe(mLoc, 3, 1'b1, (m == 1) ? "R7 off mode" : (m == 3) ? "R9 slow blink" : "R8 normal blink");
        pulseFrame();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule